// File: doc/BRIEF.md
# Power-Fail Classifier with Reboot Policy and Sleep Stretch

This block sits in the always-on domain and runs from the slow real-time clock. It watches two asynchronous inputs, the core power-good level and the active-low resume-well reset, and sorts every loss of power-good into one of two kinds. In a dip, power-good falls and comes back while the resume-well reset stays high. In a full loss, the resume-well reset also falls before power-good has returned.

A dip always ends in a restart request. A full loss ends in a restart only when the after-loss policy input asks for one. Each kind of event leaves its own sticky status flag, which software clears by writing a one.

The same block drives the suspend output that removes memory power. When the stretch enable is set, that output is held for a minimum number of real-time clock cycles, so that memory power is fully cycled even if the wake request comes early. When the stretch is off, a release that comes too early is recorded in a third sticky flag.

Top module: `pf_reboot_ctrl`

## Requirements
- R1: Power-good and the resume-well reset each pass through a two-stage synchronizer on the real-time clock. An event's restart pulse appears on the third rising clock edge after the last input change that completes it. A low pulse that does not span a rising edge has no effect.
- R2: If power-good falls and returns high while the resume-well reset stays high, the dip flag sets and a restart pulse is issued, whatever the policy input is.
- R3: If the resume-well reset falls before power-good returns, the event is a full loss. The loss flag sets once both inputs are high again. A restart pulse is issued when policy_stay_off is 0, and none is issued when it is 1.
- R4: reboot_req is high for exactly one clock per event, and only after both synchronized inputs were high.
- R5: The flags are sticky and clear only through clr_flags, which is write-one-to-clear: bit 0 clears the dip flag, bit 1 the loss flag, and bit 2 the short-sleep flag. A clear bit for a flag that is not set, or a clear bit for a different flag, leaves the set flag unchanged.
- R6: With the stretch disabled, sleep_out rises one clock after sleep_req is sampled high. It stays high for exactly as many clocks as sleep_req was sampled high.
- R7: With the stretch enabled, sleep_out stays high for the larger of the request length and MIN_HOLD clocks.
- R8: With the stretch disabled, releasing sleep_out after fewer than MIN_HOLD clocks sets the short-sleep flag. A release after MIN_HOLD or more clocks does not set it.
- R9: After reset, reboot_req, sleep_out and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Real-time clock |
| rst_n | input | 1 | Asynchronous active-low reset of the always-on domain |
| pwr_good_a | input | 1 | Core power-good, asynchronous |
| rsm_rst_n_a | input | 1 | Resume-well reset, active low, asynchronous |
| policy_stay_off | input | 1 | After-loss policy: 0 restart, 1 stay off |
| stretch_en | input | 1 | Enables the minimum hold on sleep_out |
| sleep_req | input | 1 | Request to remove memory power |
| clr_flags | input | 3 | Write-one-to-clear strobes for the flags |
| reboot_req | output | 1 | One-cycle restart request |
| sleep_out | output | 1 | Memory power removal, active high |
| flag_dip | output | 1 | Sticky: power-good dip seen |
| flag_loss | output | 1 | Sticky: full power loss seen |
| flag_short_sleep | output | 1 | Sticky: memory power was not off for the minimum time |

## Verification
The bench builds the block with MIN_HOLD set to 5 and keeps the two synchronizer stages. A hold time that short makes it practical to sweep every request length from one clock up to two clocks past the threshold, with the stretch both on and off. Each length is checked for its exact high time and for the short-sleep flag. For the classifier, the bench sweeps the dip length, the order and spacing in which the two inputs return, and both policy values. It also injects a sub-cycle power-good glitch and confirms that nothing happens.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;

    // Index of each sticky flag inside the clear vector
    localparam int FLG_DIP   = 0;
    localparam int FLG_LOSS  = 1;
    localparam int FLG_SHORT = 2;
    localparam int FLG_N     = 3;

    typedef enum logic [1:0] {
        PF_UP   = 2'd0,   // power-good high, nothing pending
        PF_DIP  = 2'd1,   // power-good low, resume-well reset still high
        PF_LOSS = 2'd2    // resume-well reset fell while power-good was low
    } pf_state_e;

    typedef struct packed {
        pf_state_e st;
        logic      reboot;
        logic      flag_dip;
        logic      flag_loss;
    } cls_regs_t;

endpackage

// File: rtl/pf_sync.sv
`timescale 1ns/1ps
module pf_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q_s
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= RST_VAL;
                    else        stg_q[s] <= d_a;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= RST_VAL;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q_s = stg_q[STAGES-1];
endmodule

// File: rtl/pf_classify.sv
`timescale 1ns/1ps
module pf_classify
    import pf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s,
    input  logic rsm_s,
    input  logic policy_off,
    input  logic clr_dip,
    input  logic clr_loss,
    output logic reboot,
    output logic flag_dip,
    output logic flag_loss
);
    localparam cls_regs_t CLS_RST = '{st: PF_UP, reboot: 1'b0, flag_dip: 1'b0, flag_loss: 1'b0};

    cls_regs_t q, d;

    always_comb begin
        d        = q;
        d.reboot = 1'b0;
        if (clr_dip)  d.flag_dip  = 1'b0;
        if (clr_loss) d.flag_loss = 1'b0;
        case (q.st)
            PF_UP: begin
                if (!pg_s) d.st = rsm_s ? PF_DIP : PF_LOSS;
            end
            PF_DIP: begin
                if (!rsm_s) begin
                    d.st = PF_LOSS;
                end else if (pg_s) begin
                    d.st       = PF_UP;
                    d.flag_dip = 1'b1;
                    d.reboot   = 1'b1;
                end
            end
            PF_LOSS: begin
                if (pg_s && rsm_s) begin
                    d.st        = PF_UP;
                    d.flag_loss = 1'b1;
                    d.reboot    = !policy_off;
                end
            end
            default: d.st = PF_UP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CLS_RST;
        else        q <= d;
    end

    assign reboot    = q.reboot;
    assign flag_dip  = q.flag_dip;
    assign flag_loss = q.flag_loss;

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.reboot |=> !q.reboot);
    assert_reboot_after_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.reboot |-> ($past(pg_s) && $past(rsm_s)));
    assert_dip_forces_reboot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag_dip) |-> q.reboot);
    assert_policy_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.flag_loss) && $past(policy_off)) |-> !q.reboot);
    assert_policy_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.flag_loss) && !$past(policy_off)) |-> q.reboot);
    assert_sticky_dip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.flag_dip) |-> $past(clr_dip));
    assert_sticky_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.flag_loss) |-> $past(clr_loss));
endmodule

// File: rtl/pf_sleep_hold.sv
`timescale 1ns/1ps
module pf_sleep_hold #(
    parameter int MIN_HOLD = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic clr_short,
    output logic out,
    output logic flag_short
);
    localparam int               CNT_W = (MIN_HOLD > 1) ? $clog2(MIN_HOLD) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_HOLD - 1);

    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic             flag_short;
    } hold_regs_t;

    hold_regs_t q, d;
    logic       done;

    // cnt_q == k-1 at the edge where the output has been high k cycles
    assign done = (q.cnt == LIMIT);

    always_comb begin
        d = q;
        if (clr_short) d.flag_short = 1'b0;
        if (!q.out) begin
            if (req) begin
                d.out = 1'b1;
                d.cnt = '0;
            end
        end else if (!req && (done || !en)) begin
            d.out = 1'b0;
            if (!done) d.flag_short = 1'b1;
        end else if (!done) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out        = q.out;
    assign flag_short = q.flag_short;

    assert_min_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.out) && $past(en)) |-> $past(done));
    assert_short_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag_short) |-> $fell(q.out));
    assert_sticky_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.flag_short) |-> $past(clr_short));
endmodule

// File: rtl/pf_reboot_ctrl.sv
`timescale 1ns/1ps
module pf_reboot_ctrl
    import pf_pkg::*;
#(
    parameter int MIN_HOLD    = 32768,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_rtc,
    input  logic             rst_n,
    input  logic             pwr_good_a,
    input  logic             rsm_rst_n_a,
    input  logic             policy_stay_off,
    input  logic             stretch_en,
    input  logic             sleep_req,
    input  logic [FLG_N-1:0] clr_flags,
    output logic             reboot_req,
    output logic             sleep_out,
    output logic             flag_dip,
    output logic             flag_loss,
    output logic             flag_short_sleep
);
    logic [1:0] raw_a;
    logic [1:0] syn_s;

    assign raw_a = {rsm_rst_n_a, pwr_good_a};

    pf_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk_rtc),
        .rst_n (rst_n),
        .d_a   (raw_a),
        .q_s   (syn_s)
    );

    pf_classify u_cls (
        .clk        (clk_rtc),
        .rst_n      (rst_n),
        .pg_s       (syn_s[0]),
        .rsm_s      (syn_s[1]),
        .policy_off (policy_stay_off),
        .clr_dip    (clr_flags[FLG_DIP]),
        .clr_loss   (clr_flags[FLG_LOSS]),
        .reboot     (reboot_req),
        .flag_dip   (flag_dip),
        .flag_loss  (flag_loss)
    );

    pf_sleep_hold #(.MIN_HOLD(MIN_HOLD)) u_hold (
        .clk        (clk_rtc),
        .rst_n      (rst_n),
        .en         (stretch_en),
        .req        (sleep_req),
        .clr_short  (clr_flags[FLG_SHORT]),
        .out        (sleep_out),
        .flag_short (flag_short_sleep)
    );

    assert_no_double_event_R4: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        !($rose(flag_dip) && $rose(flag_loss)));
endmodule

// File: tb/tb_pf_reboot_ctrl.sv
`timescale 1ns/1ps
module tb_pf_reboot_ctrl;
    localparam int MINH = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pg = 1'b1, rsm = 1'b1, pol = 1'b0, sen = 1'b0, sreq = 1'b0;
    logic [2:0] clr = 3'b000;
    logic       reboot, sout, fdip, floss, fshort;
    int         total = 0, bad = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    pf_reboot_ctrl #(.MIN_HOLD(MINH), .SYNC_STAGES(2)) dut (
        .clk_rtc(clk), .rst_n(rst_n), .pwr_good_a(pg), .rsm_rst_n_a(rsm),
        .policy_stay_off(pol), .stretch_en(sen), .sleep_req(sreq), .clr_flags(clr),
        .reboot_req(reboot), .sleep_out(sout), .flag_dip(fdip), .flag_loss(floss),
        .flag_short_sleep(fshort)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_clr(input logic [2:0] v);
        @(negedge clk); clr = v;
        @(negedge clk); clr = 3'b000;
    endtask

    // mode 0: dip only; 1: reset falls, power-good returns, reset returns gap later;
    // 2: reset falls and returns gap+1 cycles before power-good
    task automatic run_event(input int p, input int lowlen, input int mode, input int gap);
        int cnt = 0, first = 0, exp_r;
        pol = p[0];
        @(negedge clk); pg = 1'b0;
        repeat (lowlen) @(negedge clk);
        if (mode == 0) begin
            pg = 1'b1;
        end else if (mode == 1) begin
            rsm = 1'b0; @(negedge clk); pg = 1'b1;
            repeat (gap) @(negedge clk);
            rsm = 1'b1;
        end else begin
            rsm = 1'b0; @(negedge clk); rsm = 1'b1;
            repeat (gap + 1) @(negedge clk);
            pg = 1'b1;
        end
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            if (reboot) begin cnt++; if (first == 0) first = j; end
        end
        exp_r = (mode == 0) ? 1 : (p == 0 ? 1 : 0);
        check(mode == 0 ? "R2 reboot count" : "R3 reboot count", cnt, exp_r);
        if (exp_r == 1) check("R1 R4 pulse cycle", first, 3);
        check("R2 dip flag", fdip, mode == 0);
        check("R3 loss flag", floss, mode != 0);
        repeat (4) @(negedge clk);
        check("R5 dip sticky", fdip, mode == 0);
        check("R5 loss sticky", floss, mode != 0);
        pulse_clr(mode == 0 ? 3'b110 : 3'b101);
        check("R5 wrong clear ignored dip", fdip, mode == 0);
        check("R5 wrong clear ignored loss", floss, mode != 0);
        pulse_clr(3'b011);
        check("R5 cleared dip", fdip, 0);
        check("R5 cleared loss", floss, 0);
    endtask

    task automatic run_sleep(input int en, input int r);
        int cnt = 0, first = 0, exp_len;
        sen = en[0];
        @(negedge clk); sreq = 1'b1;
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            if (sout) begin cnt++; if (first == 0) first = j; end
            if (j == r) sreq = 1'b0;
        end
        exp_len = (en != 0 && r < MINH) ? MINH : r;
        check(en != 0 ? "R7 stretched length" : "R6 plain length", cnt, exp_len);
        check("R6 rise latency", first, 1);
        check("R8 short flag", fshort, (en == 0 && r < MINH) ? 1 : 0);
        pulse_clr(3'b011);
        check("R5 short kept on other clear", fshort, (en == 0 && r < MINH) ? 1 : 0);
        pulse_clr(3'b100);
        check("R5 short cleared", fshort, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset reboot", reboot, 0);
        check("R9 reset sleep", sout, 0);
        check("R9 reset dip", fdip, 0);
        check("R9 reset loss", floss, 0);
        check("R9 reset short", fshort, 0);

        // sub-cycle glitch between rising edges: must go unseen
        @(posedge clk); #0.5; pg = 1'b0; #1.0; pg = 1'b1;
        cnt = 0;
        for (int j = 0; j < 8; j++) begin @(negedge clk); if (reboot) cnt++; end
        check("R1 glitch reboot", cnt, 0);
        check("R1 glitch flag", fdip, 0);

        for (int p = 0; p < 2; p++)
            for (int l = 1; l <= 4; l++) begin
                run_event(p, l, 0, 0);
                for (int g = 0; g <= 2; g++) begin
                    run_event(p, l, 1, g);
                    run_event(p, l, 2, g);
                end
            end

        for (int e = 0; e < 2; e++)
            for (int r = 1; r <= MINH + 2; r++)
                run_sleep(e, r);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule